// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block decides which of five interrupt sources a small CPU core should service next, and at which address. The sources are two external request pins (active low), two timer overflow flags and a serial port whose request combines its receive-done and transmit-done flags. Each source is masked by its own enable bit and by one global enable. Each source carries one priority bit that puts it on the low or the high level. The external pins can be set individually to latch a falling edge or to follow a held-low level.

The CPU signals each instruction boundary with `insn_done` and the end of a handler with `reti`. At a boundary, while `irq_req` is high, the controller treats the request as taken. It raises `irq_take` for that cycle, records the winner's level as in service and pulses `flag_clr` for the flags that clear on acceptance. A request on the level already in service waits for the handler to end. A high request can interrupt a low handler. After every return, one more instruction of the interrupted code runs before another request can be taken.

The enable and priority values are loaded through two write strobes. Reset clears them, together with the latched edges and the in-service state.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0 and `in_service` is 00, even while every source is active, because all enables and priorities start cleared.
- R2: A source can be taken only while both its own enable bit (bits 4:0 of `cfg_en_wd`, in source-index order) and the global enable (bit 5) are 1.
- R3: When `ext_edge[i]` is 1, a 1-to-0 transition on `ext_pin_n[i]` latches a request. The request stays after the pin returns high and is cleared when that source is taken.
- R4: When `ext_edge[i]` is 0, external source i requests only while its pin is low, and nothing is latched.
- R5: Bit i of `cfg_pri_wd` set to 1 puts source i on the high level. With a low handler in service, a high request is offered and a low request is held back. With a high handler in service, no request is offered.
- R6: Among eligible requests of the winning level, the lowest source index wins. The index order is external 0 (0), timer 0 (1), external 1 (2), timer 1 (3), serial (4).
- R7: `irq_vec` equals 03h + 8 × index: 03h, 0Bh, 13h, 1Bh, 23h.
- R8: The serial source requests while `ser_rx_done` or `ser_tx_done` is 1.
- R9: A request is taken (`irq_take` = 1) only in a cycle with `insn_done` = 1. Without that strobe the in-service state does not change.
- R10: In the `reti` cycle and up to and including the next `insn_done` cycle, `irq_req` and `irq_take` stay 0.
- R11: `in_service` bit 1 is the high level and bit 0 the low level. Taking a request sets its level's bit. `reti` clears bit 1 if it is set, and bit 0 otherwise.
- R12: On a take, `flag_clr` pulses the winner's bit only when the winner is an edge-mode external source or a timer. For a level-mode external source or the serial source it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 2 | External request pins, active low (index 0 = external 0) |
| ext_edge | input | 2 | Trigger type per external pin: 1 falling edge, 0 low level |
| tmr_ovf | input | 2 | Timer overflow flags (index 0 = timer 0) |
| ser_rx_done | input | 1 | Serial receive-done flag |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| cfg_en_we | input | 1 | Load strobe for the enable register |
| cfg_en_wd | input | 6 | Enable value: bits 4:0 per source, bit 5 global |
| cfg_pri_we | input | 1 | Load strobe for the priority register |
| cfg_pri_wd | input | 5 | Priority value, one bit per source, 1 = high |
| insn_done | input | 1 | Instruction boundary strobe from the CPU |
| reti | input | 1 | Return-from-handler strobe from the CPU |
| irq_req | output | 1 | A request may be taken at the next boundary |
| irq_vec | output | 8 | Vector address of the offered request |
| irq_take | output | 1 | Request taken this cycle |
| flag_clr | output | 5 | One-cycle clear pulses per source on a take |
| in_service | output | 2 | In-service bits: bit 1 high level, bit 0 low level |

## Verification
The bench builds the block with its defaults: a vector base of 03h, a vector step of 8 and an 8-bit vector. With these values every vector address the CPU expects is reachable, and the five-source polling order can be checked in full. A table of enable, priority and source patterns checks masking, the polling order and high-over-low selection with nothing in service. Directed sequences then nest a high handler inside a low one, unwind both levels, and check the one-instruction gap after a return, edge latching against level following, and which flags are cleared on acceptance.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 5;
  localparam int IDXW = 3;

  typedef enum logic [IDXW-1:0] {
    SRC_X0  = 3'd0,
    SRC_T0  = 3'd1,
    SRC_X1  = 3'd2,
    SRC_T1  = 3'd3,
    SRC_SER = 3'd4
  } src_e;

  // vector address of a source index
  function automatic logic [15:0] vec_at(input int unsigned idx,
                                         input int unsigned base,
                                         input int unsigned step);
    return 16'(base + idx * step);
  endfunction

  // keep only the lowest set bit
  function automatic logic [NSRC-1:0] lowest_bit(input logic [NSRC-1:0] v);
    return v & ~(v - NSRC'(1));
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req,
  output logic fell
);
  logic pin_q;
  logic flag_q;

  assign fell = pin_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      pin_q <= pin_n;
      if (fell && edge_mode)
        flag_q <= 1'b1;
      else if (clr || !edge_mode)
        flag_q <= 1'b0;
    end
  end

  assign req = edge_mode ? flag_q : ~pin_n;
endmodule

// File: rtl/irq_pick.sv
module irq_pick import irq_pkg::*; (
  input  logic [NSRC-1:0] hi_set,
  input  logic [NSRC-1:0] lo_set,
  input  logic            isv_hi,
  input  logic            isv_lo,
  output logic            win_valid,
  output logic            win_hi,
  output logic [NSRC-1:0] win_oh,
  output logic [IDXW-1:0] win_idx
);
  logic [NSRC-1:0] cand;

  always_comb begin
    if (isv_hi)           cand = '0;
    else if (|hi_set)     cand = hi_set;
    else if (isv_lo)      cand = '0;
    else                  cand = lo_set;
    win_hi    = !isv_hi && (|hi_set);
    win_oh    = lowest_bit(cand);
    win_valid = |cand;
    win_idx   = '0;
    for (int i = 0; i < NSRC; i++)
      if (win_oh[i]) win_idx = IDXW'(i);
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  input  logic insn_done,
  output logic isv_hi,
  output logic isv_lo,
  output logic hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isv_hi <= 1'b0;
      isv_lo <= 1'b0;
      hold   <= 1'b0;
    end else begin
      if (take) begin
        if (take_hi) isv_hi <= 1'b1;
        else         isv_lo <= 1'b1;
      end else if (reti) begin
        if (isv_hi)  isv_hi <= 1'b0;
        else         isv_lo <= 1'b0;
      end
      if (reti)           hold <= 1'b1;
      else if (insn_done) hold <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl import irq_pkg::*; #(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int NEXT     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_pin_n,
  input  logic [NEXT-1:0] ext_edge,
  input  logic [1:0]      tmr_ovf,
  input  logic            ser_rx_done,
  input  logic            ser_tx_done,
  input  logic            cfg_en_we,
  input  logic [NSRC:0]   cfg_en_wd,
  input  logic            cfg_pri_we,
  input  logic [NSRC-1:0] cfg_pri_wd,
  input  logic            insn_done,
  input  logic            reti,
  output logic            irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic            irq_take,
  output logic [NSRC-1:0] flag_clr,
  output logic [1:0]      in_service
);
  localparam int GLB = NSRC;

  logic [NSRC:0]   en_q;
  logic [NSRC-1:0] pri_q;
  logic [NEXT-1:0] ext_req, ext_fell, ext_clr;
  logic [NSRC-1:0] raw_req, act, hi_set, lo_set, clr_mask;
  logic            win_valid, win_hi, isv_hi, isv_lo, hold;
  logic [NSRC-1:0] win_oh;
  logic [IDXW-1:0] win_idx;
  logic            glob_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (cfg_en_we)  en_q  <= cfg_en_wd;
      if (cfg_pri_we) pri_q <= cfg_pri_wd;
    end
  end

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    assign ext_clr[g] = flag_clr[2*g];
    irq_edge_latch u_lat (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n[g]), .edge_mode(ext_edge[g]),
      .clr(ext_clr[g]), .req(ext_req[g]), .fell(ext_fell[g])
    );
  end

  always_comb begin
    raw_req          = '0;
    raw_req[SRC_X0]  = ext_req[0];
    raw_req[SRC_T0]  = tmr_ovf[0];
    raw_req[SRC_X1]  = ext_req[1];
    raw_req[SRC_T1]  = tmr_ovf[1];
    raw_req[SRC_SER] = ser_rx_done | ser_tx_done;
    clr_mask          = '0;
    clr_mask[SRC_X0]  = ext_edge[0];
    clr_mask[SRC_T0]  = 1'b1;
    clr_mask[SRC_X1]  = ext_edge[1];
    clr_mask[SRC_T1]  = 1'b1;
  end

  assign glob_en = en_q[GLB];
  assign act     = raw_req & en_q[NSRC-1:0] & {NSRC{glob_en}};
  assign hi_set  = act & pri_q;
  assign lo_set  = act & ~pri_q;

  irq_pick u_pick (
    .hi_set(hi_set), .lo_set(lo_set), .isv_hi(isv_hi), .isv_lo(isv_lo),
    .win_valid(win_valid), .win_hi(win_hi), .win_oh(win_oh), .win_idx(win_idx)
  );

  assign irq_req  = win_valid & ~hold & ~reti;
  assign irq_take = irq_req & insn_done;
  assign irq_vec  = VEC_W'(vec_at(int'(win_idx), VEC_BASE, VEC_STEP));
  assign flag_clr = irq_take ? (win_oh & clr_mask) : '0;

  irq_level_track u_lvl (
    .clk(clk), .rst_n(rst_n), .take(irq_take), .take_hi(win_hi), .reti(reti),
    .insn_done(insn_done), .isv_hi(isv_hi), .isv_lo(isv_lo), .hold(hold)
  );

  assign in_service = {isv_hi, isv_lo};
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_done,
  input logic       reti,
  input logic       irq_req,
  input logic [7:0] irq_vec,
  input logic       irq_take,
  input logic [4:0] flag_clr,
  input logic [1:0] in_service,
  input logic       glob_en
);
  a_r9_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> insn_done);
  a_r10_quiet_after_return: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> !irq_take);
  a_r5_high_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    in_service[1] |-> !irq_req);
  a_r11_return_drops_high: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && in_service[1]) |=> (!in_service[1] && in_service[0] == $past(in_service[0])));
  a_r11_return_drops_low: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !in_service[1]) |=> !in_service[0]);
  a_r12_clear_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr != 5'd0) |-> (irq_take && $onehot0(flag_clr)));
  a_r2_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq_req);
  a_r7_vector_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec inside {8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23}));
  a_r11_take_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (in_service != 2'b00));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .reti(reti),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_take(irq_take),
  .flag_clr(flag_clr), .in_service(in_service), .glob_en(glob_en)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_pin_n = 2'b00;
  logic [1:0] ext_edge = 2'b00;
  logic [1:0] tmr_ovf = 2'b11;
  logic       ser_rx_done = 1'b1, ser_tx_done = 1'b0;
  logic       cfg_en_we = 1'b0, cfg_pri_we = 1'b0;
  logic [5:0] cfg_en_wd = '0;
  logic [4:0] cfg_pri_wd = '0;
  logic       insn_done = 1'b0, reti = 1'b0;
  logic       irq_req, irq_take;
  logic [7:0] irq_vec;
  logic [4:0] flag_clr;
  logic [1:0] in_service;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_vec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
    .cfg_en_we(cfg_en_we), .cfg_en_wd(cfg_en_wd), .cfg_pri_we(cfg_pri_we),
    .cfg_pri_wd(cfg_pri_wd), .insn_done(insn_done), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_take(irq_take),
    .flag_clr(flag_clr), .in_service(in_service)
  );

  // {en[5:0], pri[4:0], src[4:0], exp_req, exp_vec[7:0]}
  localparam logic [24:0] TBL [10] = '{
    {6'h3F, 5'b00000, 5'b11111, 1'b1, 8'h03},
    {6'h3F, 5'b00000, 5'b11110, 1'b1, 8'h0B},
    {6'h3F, 5'b00000, 5'b11100, 1'b1, 8'h13},
    {6'h3F, 5'b00000, 5'b11000, 1'b1, 8'h1B},
    {6'h3F, 5'b00000, 5'b10000, 1'b1, 8'h23},
    {6'h1F, 5'b00000, 5'b11111, 1'b0, 8'h00},
    {6'h3E, 5'b00000, 5'b00011, 1'b1, 8'h0B},
    {6'h3F, 5'b10000, 5'b11111, 1'b1, 8'h23},
    {6'h3F, 5'b01010, 5'b11111, 1'b1, 8'h0B},
    {6'h20, 5'b00000, 5'b11111, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_src(input logic [4:0] s);
    ext_pin_n[0] = ~s[0];
    tmr_ovf[0]   = s[1];
    ext_pin_n[1] = ~s[2];
    tmr_ovf[1]   = s[3];
    ser_rx_done  = s[4];
  endtask

  task automatic cfg(input logic [5:0] en, input logic [4:0] pri);
    cfg_en_we = 1; cfg_en_wd = en; cfg_pri_we = 1; cfg_pri_wd = pri;
    @(negedge clk);
    cfg_en_we = 0; cfg_pri_we = 0;
  endtask

  task automatic pulse_reti;
    reti = 1; @(negedge clk); reti = 0; #1;
  endtask

  task automatic pulse_boundary;
    insn_done = 1; @(negedge clk); insn_done = 0; #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 req after reset", irq_req, 0);
    chk("R1 in_service after reset", in_service, 0);

    // table walk: masking, polling order, priority selection
    for (int i = 0; i < 10; i++) begin
      set_src(TBL[i][13:9]);
      cfg(TBL[i][24:19], TBL[i][18:14]);
      #1;
      chk($sformatf("R2/R6 req row %0d", i), irq_req, TBL[i][8]);
      if (TBL[i][8]) chk($sformatf("R7/R6 vec row %0d", i), irq_vec, TBL[i][7:0]);
    end

    // serial via transmit-done, boundary gating
    set_src(5'b00000);
    cfg(6'h3F, 5'b00000);
    ser_tx_done = 1; #1;
    chk("R8 serial tx req", irq_req, 1);
    chk("R8 serial vec", irq_vec, 8'h23);
    repeat (3) @(negedge clk);
    #1;
    chk("R9 no take without boundary", in_service, 0);
    insn_done = 1; #1;
    chk("R9 take at boundary", irq_take, 1);
    chk("R12 serial not cleared", flag_clr, 0);
    @(negedge clk); insn_done = 0; ser_tx_done = 0; #1;
    chk("R11 low level set", in_service, 2'b01);
    pulse_reti;
    pulse_boundary;

    // nesting: timer0 low, timer1 high, ext1 low waiting
    cfg(6'h3F, 5'b01000);
    tmr_ovf[0] = 1; #1;
    chk("R7 timer0 vec", irq_vec, 8'h0B);
    insn_done = 1; #1;
    chk("R9 timer0 take", irq_take, 1);
    chk("R12 timer0 clear", flag_clr, 5'b00010);
    @(negedge clk); insn_done = 0; tmr_ovf[0] = 0; #1;
    chk("R11 low in service", in_service, 2'b01);
    ext_pin_n[1] = 0; #1;
    chk("R5 same level waits", irq_req, 0);
    tmr_ovf[1] = 1; #1;
    chk("R5 high preempts", irq_req, 1);
    chk("R7 timer1 vec", irq_vec, 8'h1B);
    insn_done = 1; #1;
    chk("R12 timer1 clear", flag_clr, 5'b01000);
    @(negedge clk); insn_done = 0; tmr_ovf[1] = 0; #1;
    chk("R11 both levels", in_service, 2'b11);
    chk("R5 nothing above high", irq_req, 0);
    pulse_reti;
    chk("R11 return drops high", in_service, 2'b01);
    pulse_reti;
    chk("R11 return drops low", in_service, 2'b00);
    chk("R10 req held after return", irq_req, 0);
    insn_done = 1; #1;
    chk("R10 no take on first boundary", irq_take, 0);
    @(negedge clk); insn_done = 0; #1;
    chk("R10 req after one instruction", irq_req, 1);
    chk("R7 ext1 vec", irq_vec, 8'h13);
    insn_done = 1; #1;
    chk("R12 level ext not cleared", flag_clr, 0);
    @(negedge clk); insn_done = 0; ext_pin_n[1] = 1;
    pulse_reti;
    pulse_boundary;

    // edge versus level on external 0
    cfg(6'h3F, 5'b00000);
    ext_edge[0] = 1; ext_pin_n[0] = 1;
    @(negedge clk);
    ext_pin_n[0] = 0;
    @(negedge clk); #1;
    chk("R3 edge latched", irq_req, 1);
    ext_pin_n[0] = 1;
    @(negedge clk); #1;
    chk("R3 held after pin high", irq_req, 1);
    chk("R7 ext0 vec", irq_vec, 8'h03);
    insn_done = 1; #1;
    chk("R12 edge ext clear", flag_clr, 5'b00001);
    @(negedge clk); insn_done = 0;
    pulse_reti;
    pulse_boundary;
    chk("R3 latch cleared by take", irq_req, 0);
    ext_edge[0] = 0; ext_pin_n[0] = 0; #1;
    chk("R4 level low requests", irq_req, 1);
    ext_pin_n[0] = 1; #1;
    chk("R4 level not latched", irq_req, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule